// File: doc/BRIEF.md
# Timed Flash Block Erase Sequencer

This block drives the control lines of an on-chip flash array through one block erase. A one-cycle start pulse latches a block-select mask and a target address. The block then steps through a fixed series of phases. First it raises write-enable. After a minimum settling delay it presents the block mask and arms a watchdog. It then raises erase-setup for the control set that owns the target address. After the setup delay it raises erase-enable for a fixed erase time. Finally it releases erase-setup, the watchdog and write-enable in turn, each after a fixed hold.

Every phase length is a whole number of clock cycles, computed from a clock-frequency parameter by rounding the required time up. The surrounding controller must service the watchdog through a kick input. If the kicks stop while erase-setup or erase-enable is active, the erase ends at once. There is no pre-programming pass before the erase. The erase-verify loop and the flash array itself live outside the block.

Top module: `fes_erase_seq`

## Requirements
- R1: After reset, write-enable, block-select, erase-setup, erase-enable, watchdog-armed, busy, done, error and abort are all low.
- R2: Write-enable rises one cycle after the start pulse is sampled, and it stays high for exactly ceil(10 µs × CLK_HZ) cycles before block-select shows the latched mask.
- R3: The watchdog is armed in the same cycle that the mask appears, one cycle before erase-setup rises. Erase-setup is never high while the watchdog is disarmed.
- R4: Erase-setup stays high for exactly ceil(200 µs × CLK_HZ) cycles before erase-enable rises. Erase-enable is only ever high on a set whose erase-setup is also high.
- R5: Erase-enable stays high for exactly ceil(5 ms × CLK_HZ) cycles.
- R6: Erase-setup falls ceil(10 µs × CLK_HZ) cycles after erase-enable falls. After the same number of further cycles, the watchdog disarms and write-enable and block-select clear. In that same cycle done pulses high for one cycle.
- R7: The control set is chosen by address bits [ADDR_W-1:SET_LOG2]. With the defaults, bit 17 = 0 (0x00000–0x1FFFF) selects erase-setup/erase-enable bit 0, and bit 17 = 1 (0x20000–0x3FFFF) selects bit 1. The bits of the other set stay low.
- R8: The sequence has no phase other than those above. Busy stays high for exactly T_WE + 1 + T_SETUP + T_ERASE + 2·T_HOLD + 1 cycles.
- R9: A start pulse that arrives while busy is ignored. The mask, the control set and all phase timings stay those of the running erase, and no second erase follows.
- R10: A start pulse with an all-zero mask raises busy, done and error for exactly one cycle. Write-enable never rises.
- R11: The watchdog counter restarts on each kick. If kicks are missing for ceil(5.3 µs × CLK_HZ) consecutive cycles while erase-setup or erase-enable is high, then in the next cycle every control output is low and abort pulses for one cycle without done. The block is idle the cycle after that.
- R12: A watchdog expiry while neither erase-setup nor erase-enable is high does not abort the erase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle request to begin an erase |
| blk_mask_i | input | NUM_BLK | Blocks to erase, latched on start |
| addr_i | input | ADDR_W | Target address; upper bits pick the control set |
| wdt_kick_i | input | 1 | Watchdog service pulse from the controller |
| we_o | output | 1 | Write-enable control bit |
| blk_sel_o | output | NUM_BLK | Block-select control field |
| esu_o | output | NUM_SETS | Erase-setup bit, one per control set |
| ers_o | output | NUM_SETS | Erase-enable bit, one per control set |
| wdt_armed_o | output | 1 | Watchdog is armed |
| busy_o | output | 1 | A sequence is in progress |
| done_o | output | 1 | One-cycle pulse at the end of a sequence |
| err_o | output | 1 | With done: the mask was empty |
| abort_o | output | 1 | One-cycle pulse when the watchdog ended the erase |

## Verification
Every non-zero mask of a four-block configuration is erased. The addresses cover both ends of each control-set range, so the bench can catch a wrong set decode and a mask that is latched or shown badly. Every phase edge is timed against a length computed from the microsecond figures. An empty mask is checked apart from the others. So is a second start pulse during a run, which shows whether the design restarts or re-latches. The kicks are cut off inside the setup phase, inside the erase phase and inside the final hold. This shows whether the guard acts only while setup or erase is active.

// File: rtl/fes_pkg.sv
package fes_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_WREN,
        ST_ARM,
        ST_SETUP,
        ST_ERASE,
        ST_HOLD_E,
        ST_HOLD_S,
        ST_DONE,
        ST_ABORT
    } fes_state_e;

    // Cycles needed to cover a duration in nanoseconds, rounded up, at least one.
    function automatic longint ns_to_cyc(input longint hz, input longint ns);
        longint c;
        c = (hz * ns + 64'd999_999_999) / 64'd1_000_000_000;
        if (c < 1) c = 1;
        return c;
    endfunction

endpackage

// File: rtl/fes_phase_timer.sv
module fes_phase_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         restart_i,
    input  logic [W-1:0] len_i,
    output logic         expired_o
);
    logic [W-1:0] cnt_d, cnt_q;

    assign expired_o = (cnt_q == len_i - W'(1));

    always_comb begin
        cnt_d = cnt_q;
        if (restart_i)       cnt_d = '0;
        else if (!expired_o) cnt_d = cnt_q + W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R5: a phase never runs past its programmed length
    p_len_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart_i && $stable(len_i) && expired_o) |=> (expired_o || restart_i || !$stable(len_i)));

endmodule

// File: rtl/fes_watchdog.sv
module fes_watchdog #(
    parameter int LIMIT = 8,
    parameter int W     = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm_i,
    input  logic kick_i,
    output logic overflow_o
);
    logic [W-1:0] cnt_d, cnt_q;

    assign overflow_o = arm_i && !kick_i && (cnt_q == W'(LIMIT - 1));

    always_comb begin
        cnt_d = cnt_q;
        if (!arm_i || kick_i)          cnt_d = '0;
        else if (cnt_q != W'(LIMIT-1)) cnt_d = cnt_q + W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R11: a kick always clears the pending expiry
    p_kick_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (arm_i && kick_i) |=> (cnt_q == '0));

    // R12: a disarmed guard starts from zero
    p_disarm_reset_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !arm_i |=> (cnt_q == '0));

endmodule

// File: rtl/fes_set_decode.sv
module fes_set_decode #(
    parameter int NUM_SETS = 2,
    parameter int SET_W    = $clog2(NUM_SETS)
) (
    input  logic [SET_W-1:0]    idx_i,
    output logic [NUM_SETS-1:0] onehot_o
);
    for (genvar g = 0; g < NUM_SETS; g++) begin : g_set
        assign onehot_o[g] = (idx_i == SET_W'(g));
    end
endmodule

// File: rtl/fes_erase_seq.sv
module fes_erase_seq
    import fes_pkg::*;
#(
    parameter longint CLK_HZ   = 50_000_000,
    parameter int     NUM_BLK  = 8,
    parameter int     NUM_SETS = 2,
    parameter int     SET_LOG2 = 17,
    parameter int     ADDR_W   = SET_LOG2 + $clog2(NUM_SETS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [NUM_BLK-1:0]  blk_mask_i,
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic                wdt_kick_i,
    output logic                we_o,
    output logic [NUM_BLK-1:0]  blk_sel_o,
    output logic [NUM_SETS-1:0] esu_o,
    output logic [NUM_SETS-1:0] ers_o,
    output logic                wdt_armed_o,
    output logic                busy_o,
    output logic                done_o,
    output logic                err_o,
    output logic                abort_o
);
    localparam int C_WREN  = int'(ns_to_cyc(CLK_HZ, 10_000));
    localparam int C_SETUP = int'(ns_to_cyc(CLK_HZ, 200_000));
    localparam int C_ERASE = int'(ns_to_cyc(CLK_HZ, 5_000_000));
    localparam int C_HOLD  = int'(ns_to_cyc(CLK_HZ, 10_000));
    localparam int C_WDT   = int'(ns_to_cyc(CLK_HZ, 5_300));
    localparam int TMR_W   = $clog2(C_ERASE + 1);
    localparam int SET_W   = $clog2(NUM_SETS);

    typedef struct packed {
        fes_state_e         state;
        logic [NUM_BLK-1:0] mask;
        logic [SET_W-1:0]   set_idx;
        logic               err;
    } seq_t;

    seq_t seq_d, seq_q;

    logic               phase_end;
    logic               wdt_ovf;
    logic               wdt_arm;
    logic               esu_phase;
    logic [TMR_W-1:0]   phase_len;
    logic [NUM_SETS-1:0] set_oh;
    logic               unused_addr_lo;

    assign unused_addr_lo = ^addr_i[SET_LOG2-1:0];

    // ---------------- phase length and guard windows ----------------
    always_comb begin
        case (seq_q.state)
            ST_WREN:              phase_len = TMR_W'(C_WREN);
            ST_SETUP:             phase_len = TMR_W'(C_SETUP);
            ST_ERASE:             phase_len = TMR_W'(C_ERASE);
            ST_HOLD_E, ST_HOLD_S: phase_len = TMR_W'(C_HOLD);
            default:              phase_len = TMR_W'(1);
        endcase
    end

    assign esu_phase = (seq_q.state == ST_SETUP) || (seq_q.state == ST_ERASE) ||
                       (seq_q.state == ST_HOLD_E);
    assign wdt_arm   = esu_phase || (seq_q.state == ST_ARM) || (seq_q.state == ST_HOLD_S);

    // ---------------- next-state ----------------
    always_comb begin
        seq_d = seq_q;
        case (seq_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    seq_d.mask    = blk_mask_i;
                    seq_d.set_idx = addr_i[ADDR_W-1 -: SET_W];
                    seq_d.err     = (blk_mask_i == '0);
                    seq_d.state   = (blk_mask_i == '0) ? ST_DONE : ST_WREN;
                end
            end
            ST_WREN:   if (phase_end) seq_d.state = ST_ARM;
            ST_ARM:    seq_d.state = ST_SETUP;
            ST_SETUP: begin
                if (wdt_ovf)        seq_d.state = ST_ABORT;
                else if (phase_end) seq_d.state = ST_ERASE;
            end
            ST_ERASE: begin
                if (wdt_ovf)        seq_d.state = ST_ABORT;
                else if (phase_end) seq_d.state = ST_HOLD_E;
            end
            ST_HOLD_E: begin
                if (wdt_ovf)        seq_d.state = ST_ABORT;
                else if (phase_end) seq_d.state = ST_HOLD_S;
            end
            ST_HOLD_S: if (phase_end) seq_d.state = ST_DONE;
            ST_DONE:   seq_d.state = ST_IDLE;
            ST_ABORT:  seq_d.state = ST_IDLE;
            default:   seq_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '{state: ST_IDLE, mask: '0, set_idx: '0, err: 1'b0};
        else        seq_q <= seq_d;
    end

    // ---------------- sub-blocks ----------------
    fes_phase_timer #(.W(TMR_W)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (seq_d.state != seq_q.state),
        .len_i     (phase_len),
        .expired_o (phase_end)
    );

    fes_watchdog #(.LIMIT(C_WDT)) u_wdog (
        .clk        (clk),
        .rst_n      (rst_n),
        .arm_i      (wdt_arm),
        .kick_i     (wdt_kick_i),
        .overflow_o (wdt_ovf)
    );

    fes_set_decode #(.NUM_SETS(NUM_SETS), .SET_W(SET_W)) u_dec (
        .idx_i    (seq_q.set_idx),
        .onehot_o (set_oh)
    );

    // ---------------- outputs ----------------
    assign we_o        = (seq_q.state == ST_WREN) || wdt_arm;
    assign blk_sel_o   = wdt_arm ? seq_q.mask : '0;
    assign esu_o       = esu_phase ? set_oh : '0;
    assign ers_o       = (seq_q.state == ST_ERASE) ? set_oh : '0;
    assign wdt_armed_o = wdt_arm;
    assign busy_o      = (seq_q.state != ST_IDLE);
    assign done_o      = (seq_q.state == ST_DONE);
    assign err_o       = (seq_q.state == ST_DONE) && seq_q.err;
    assign abort_o     = (seq_q.state == ST_ABORT);

    // ---------------- assertions ----------------
    p_sel_after_we_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(|blk_sel_o) |-> $past(we_o));

    p_esu_needs_arm_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (|esu_o) |-> wdt_armed_o);

    p_ers_inside_esu_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|ers_o) |-> ((ers_o & ~esu_o) == '0));

    p_esu_after_ers_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(|ers_o) && !abort_o) |-> (|esu_o));

    p_one_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(esu_o));

    p_zero_mask_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i && blk_mask_i == '0) |=> (done_o && err_o && !we_o));

    p_abort_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        abort_o |-> (!we_o && blk_sel_o == '0 && esu_o == '0 && ers_o == '0 && !wdt_armed_o && !done_o));

    p_abort_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        abort_o |=> !busy_o);

endmodule

// File: tb/sim_fes_erase_seq.sv
module sim_fes_erase_seq;
    localparam longint HZ = 1_000_000;
    localparam int NB = 4;
    localparam int AW = 18;
    // Expected lengths from the requirement figures at 1 MHz
    localparam int E_WE    = 10;     // 10 us
    localparam int E_SETUP = 200;    // 200 us
    localparam int E_ERASE = 5000;   // 5 ms
    localparam int E_HOLD  = 10;     // 10 us
    localparam int E_WDT   = 6;      // 5.3 us rounded up

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, kick = 1'b0;
    logic [NB-1:0] mask = '0;
    logic [AW-1:0] addr = '0;
    logic we, armed, busy, done, err, abrt;
    logic [NB-1:0] bsel;
    logic [1:0] esu, ers;
    bit kick_en = 1'b0;
    int checks = 0, fails = 0;

    always #5 clk = ~clk;

    fes_erase_seq #(.CLK_HZ(HZ), .NUM_BLK(NB), .NUM_SETS(2), .SET_LOG2(17)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start), .blk_mask_i(mask), .addr_i(addr),
        .wdt_kick_i(kick), .we_o(we), .blk_sel_o(bsel), .esu_o(esu), .ers_o(ers),
        .wdt_armed_o(armed), .busy_o(busy), .done_o(done), .err_o(err), .abort_o(abrt));

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    initial begin : kicker
        int ph = 0;
        forever begin
            @(negedge clk);
            ph = (ph + 1) % 3;
            kick = kick_en && (ph == 0);
        end
    end

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog run did not finish actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    task automatic run_seq(input logic [NB-1:0] m, input logic [AW-1:0] a,
                           input int poke_at, input int stop_at, input bit exp_abort);
        int t_we = -1, t_sel = -1, t_arm = -1, t_esu = -1, t_ers = -1, t_ersf = -1;
        int t_esuf = -1, t_armf = -1, t_wef = -1, t_done = -1, t_abort = -1, t_end = -1;
        logic [NB-1:0] sel_v = '0;
        logic [1:0] esu_v = '0, ers_v = '0, exp_set;
        bit quiet_ok = 1'b1;
        int e_sel, e_esu, e_ers, e_ersf, e_esuf, e_done;
        exp_set = a[17] ? 2'b10 : 2'b01;
        @(negedge clk);
        mask = m; addr = a; start = 1'b1; kick_en = 1'b1;
        for (int k = 1; k < 8000; k++) begin
            @(negedge clk);
            if (we && t_we < 0) t_we = k;
            if (|bsel && t_sel < 0) begin t_sel = k; sel_v = bsel; end
            if (armed && t_arm < 0) t_arm = k;
            if (|esu && t_esu < 0) begin t_esu = k; esu_v = esu; end
            if (|ers && t_ers < 0) begin t_ers = k; ers_v = ers; end
            if (t_ers >= 0 && !(|ers) && t_ersf < 0) t_ersf = k;
            if (t_esu >= 0 && !(|esu) && t_esuf < 0) t_esuf = k;
            if (t_arm >= 0 && !armed && t_armf < 0) t_armf = k;
            if (t_we >= 0 && !we && t_wef < 0) t_wef = k;
            if (done && t_done < 0) t_done = k;
            if (abrt && t_abort < 0) begin
                t_abort = k;
                quiet_ok = !we && bsel == '0 && esu == '0 && ers == '0 && !armed;
            end
            if (!busy) begin t_end = k; break; end
            start = (k == poke_at);
            if (k == poke_at) begin mask = ~m; addr = a ^ 18'h20000; end
            if (k == stop_at) kick_en = 1'b0;
        end
        start = 1'b0;
        e_sel = 1 + E_WE; e_esu = e_sel + 1; e_ers = e_esu + E_SETUP;
        e_ersf = e_ers + E_ERASE; e_esuf = e_ersf + E_HOLD; e_done = e_esuf + E_HOLD;
        chk(t_we == 1, "R2 we rise", t_we, 1);
        chk(t_sel == e_sel, "R2 mask after we delay", t_sel, e_sel);
        chk(sel_v == m, "R2 mask value", sel_v, m);
        chk(t_arm == e_sel, "R3 watchdog armed with mask", t_arm, e_sel);
        chk(t_esu == e_esu, "R3 setup one cycle after arm", t_esu, e_esu);
        chk(esu_v == exp_set, "R7 setup set", esu_v, exp_set);
        if (exp_abort) begin
            chk(t_abort > stop_at && t_abort <= stop_at + E_WDT + 2, "R11 abort timing", t_abort, stop_at + E_WDT);
            chk(quiet_ok, "R11 outputs low on abort", quiet_ok, 1);
            chk(t_done < 0, "R11 no done after abort", t_done, -1);
            chk(t_end == t_abort + 1, "R11 idle after abort", t_end, t_abort + 1);
        end else begin
            chk(t_ers == e_ers, "R4 setup delay", t_ers, e_ers);
            chk(ers_v == exp_set, "R7 erase set", ers_v, exp_set);
            chk(t_ersf == e_ersf, "R5 erase width", t_ersf - t_ers, E_ERASE);
            chk(t_esuf == e_esuf, "R6 setup hold", t_esuf, e_esuf);
            chk(t_done == e_done && t_armf == e_done && t_wef == e_done, "R6 final release", t_done, e_done);
            chk(t_end == e_done + 1, "R8 busy length", t_end - t_we, e_done + 1 - 1);
            chk(t_abort < 0, "R12 no abort", t_abort, -1);
        end
        repeat (3) begin
            @(negedge clk);
            chk(!busy, "R9 no follow-up run", busy, 0);
        end
        kick_en = 1'b1;
    endtask

    initial begin : main
        repeat (3) @(negedge clk);
        chk(!we && bsel == '0 && esu == '0 && ers == '0 && !armed && !busy && !done && !err && !abrt,
            "R1 reset state", {we, bsel, esu, ers, armed, busy, done, err, abrt}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R10: empty mask
        mask = '0; addr = 18'h20000; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy && done && err && !we, "R10 empty mask result", {busy, done, err, we}, 4'b1110);
        @(negedge clk);
        chk(!busy && !done && !we, "R10 back to idle", {busy, done, we}, 0);

        // R2-R8: every non-zero mask, both set ranges and their ends; R9 poke on mask 5
        for (int m = 1; m < 16; m++) begin
            logic [AW-1:0] a;
            case (m)
                1: a = 18'h1FFFF;
                2: a = 18'h20000;
                3: a = 18'h3FFFF;
                4: a = 18'h00000;
                default: a = m[0] ? AW'(18'h20000 + m * 123) : AW'(m * 321);
            endcase
            run_seq(NB'(m), a, (m == 5) ? 5 : -1, -1, 1'b0);
        end

        // R11: kicks stop in setup and in erase; R12: kicks stop in the last hold
        run_seq(4'b0011, 18'h00100, -1, 62, 1'b1);
        run_seq(4'b1100, 18'h30000, -1, 1000, 1'b1);
        run_seq(4'b0110, 18'h10000, -1, 1 + E_WE + 1 + E_SETUP + E_ERASE + E_HOLD, 1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule